// File: doc/BRIEF.md
# Code Protection Lock and Verify Scrambler

This block guards the on-chip program store when its contents are read back on a verify port, and when code runs from outside the chip. It keeps two pieces of protection state as registers. The first is a 64-entry scrambling table of bytes. The second is three lock fuses, written through a small programming port and cleared as a group by one erase command. Every verify read takes the raw code byte supplied by the array and returns that byte XNOR-ed with the table entry picked by the low six address bits. The read is refused outright when the lock level is high enough.

The block also drives three permission levels to the rest of the chip: whether table-read instructions running from external memory may fetch internal bytes, whether the array may be programmed further, and whether external execution is allowed. It also gives an effective external-access strap. This strap follows its pin while the part is unlocked and holds the value captured during reset once any lock is set. A signature read port returns fixed identification bytes, and the lock level never blocks it.

The three fuses map to four lock levels. Level 1 closes the external table-read path and further programming. Level 2 also refuses verify reads. Level 3 also refuses external execution. A fuse combination that the level ladder does not define counts as the level of the highest-numbered fuse that is burned. Burning a fuse therefore never lowers protection.

Top module: `codeguard_top`

## Requirements
- R1: While `rst` is high and in the cycle after it, every table entry reads 0xFF, all three fuses are intact (level 0), `rd_valid` and `rd_blocked` are 0, `rd_data` is 0xFF, and `ext_tblrd_ok`, `prog_ok` and `ext_exec_ok` are 1.
- R2: A read request (`rd_req`=1, `rd_sig`=0) at level 0 or 1 gives `rd_valid`=1 one cycle later, with `rd_data` = ~(`rd_code` ^ table[`rd_addr`[5:0]]). The upper address bits play no part. With no request, `rd_valid` is 0 and `rd_data` holds its previous value.
- R3: A table write (`prog_wr`=1) allowed by `prog_ok` ANDs `prog_data` into entry `prog_idx`, so bits can only be cleared. An untouched entry (0xFF) returns code unchanged, and a code byte of 0xFF reads back as the entry itself.
- R4: `lock_burn`=1 with `lock_sel`=1, 2 or 3 burns fuse 1, 2 or 3, and `lock_sel`=0 has no effect. The level is the number of the highest burned fuse, or 0 with none burned.
- R5: At level 1 or above, `ext_tblrd_ok` and `prog_ok` are 0, table writes leave the table unchanged, and `ea_eff` holds the value `ea_pin` had in the last reset cycle. At level 0, `ea_eff` follows `ea_pin` directly.
- R6: A verify request made at level 2 or 3 returns `rd_data`=0xFF with `rd_blocked`=1 for that one response cycle.
- R7: `ext_exec_ok` is 0 exactly at level 3.
- R8: `erase`=1 returns every table entry to 0xFF and every fuse to intact on the next edge. It wins over a table write or fuse burn given in the same cycle.
- R9: A signature read (`rd_req`=1, `rd_sig`=1) returns 0x89 at address 0x30, 0x58 at 0x31, `DEV_CODE` at 0x60, and 0xFF at any other address. Its response is never blocked at any level.
- R10: Fuse burns are accepted at every level, so without erase the level never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; samples the strap pin |
| ea_pin | input | 1 | External-access strap pin |
| prog_wr | input | 1 | Table write strobe |
| prog_idx | input | IDX_W | Table entry index |
| prog_data | input | 8 | Byte ANDed into the entry |
| lock_burn | input | 1 | Fuse burn strobe |
| lock_sel | input | 2 | Fuse number 1..3, 0 ignored |
| erase | input | 1 | Erase table and fuses |
| rd_req | input | 1 | Read request |
| rd_sig | input | 1 | 1 = signature read, 0 = verify read |
| rd_addr | input | ADDR_W | Read address |
| rd_code | input | 8 | Raw code byte from the array |
| rd_valid | output | 1 | Response valid |
| rd_data | output | 8 | Response byte |
| rd_blocked | output | 1 | Verify read refused |
| ext_tblrd_ok | output | 1 | External table reads may fetch internal code |
| prog_ok | output | 1 | Array programming allowed |
| ext_exec_ok | output | 1 | External execution allowed |
| ea_eff | output | 1 | Effective external-access strap |

## Verification
The bench targets a repeated write to the same table entry. A design that overwrites instead of ANDing would show the second byte instead of the intersection. It reads addresses whose upper bits differ but whose low six bits match, which catches a wrong index slice. It burns only fuse 3 after an erase, where a design that decodes only the defined combinations would leave verify or execution open. It also drives erase together with a write and a burn in one cycle, and toggles the strap pin while locked, so a strap that still follows the pin after a fuse is burned shows up at once.

// File: rtl/codeguard_pkg.sv
package codeguard_pkg;

    typedef logic [7:0] byte_t;

    // protection ladder, ordered so that a larger value never grants more
    typedef enum logic [1:0] {
        LVL_OPEN   = 2'd0,
        LVL_NOTBL  = 2'd1,
        LVL_NOVFY  = 2'd2,
        LVL_NOEXEC = 2'd3
    } lock_lvl_e;

    typedef struct packed {
        logic tblrd_ok;
        logic prog_ok;
        logic exec_ok;
    } gate_t;

    typedef struct packed {
        logic  valid;
        logic  blocked;
        byte_t data;
    } rd_resp_t;

    localparam byte_t SIG_MFR_VAL = 8'h89;
    localparam byte_t SIG_FAM_VAL = 8'h58;
    localparam int    SIG_MFR_ADR = 'h30;
    localparam int    SIG_FAM_ADR = 'h31;
    localparam int    SIG_DEV_ADR = 'h60;
    localparam byte_t BLANK       = 8'hFF;

    // fuse bit i low = fuse i+1 burned; highest burned fuse sets the level
    function automatic lock_lvl_e level_of(input logic [2:0] fuse);
        if (!fuse[2])      return LVL_NOEXEC;
        else if (!fuse[1]) return LVL_NOVFY;
        else if (!fuse[0]) return LVL_NOTBL;
        else               return LVL_OPEN;
    endfunction

    function automatic gate_t gates_of(input lock_lvl_e lvl);
        gate_t g;
        g.tblrd_ok = (lvl == LVL_OPEN);
        g.prog_ok  = (lvl == LVL_OPEN);
        g.exec_ok  = (lvl != LVL_NOEXEC);
        return g;
    endfunction

    function automatic logic verify_refused(input lock_lvl_e lvl);
        return (lvl == LVL_NOVFY) || (lvl == LVL_NOEXEC);
    endfunction

    function automatic byte_t scramble(input byte_t code, input byte_t key);
        return ~(code ^ key);
    endfunction

endpackage

// File: rtl/cg_scramble_table.sv
module cg_scramble_table
    import codeguard_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             erase,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  byte_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output byte_t            rd_byte
);

    byte_t ent [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst || erase)
                ent[i] <= BLANK;
            else if (wr_en && (wr_idx == IDX_W'(i)))
                ent[i] <= ent[i] & wr_data;
        end
    end

    assign rd_byte = ent[rd_idx];

endmodule

// File: rtl/cg_lock_ctrl.sv
module cg_lock_ctrl
    import codeguard_pkg::*;
#(
    parameter int NFUSE = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      erase,
    input  logic      burn_en,
    input  logic [1:0] burn_sel,
    input  logic      ea_pin,
    output lock_lvl_e lvl,
    output gate_t     gates,
    output logic      ea_eff
);

    logic [NFUSE-1:0] fuse;
    logic             ea_latch;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NFUSE; i++) begin
            if (rst || erase)
                fuse[i] <= 1'b1;
            else if (burn_en && (burn_sel == 2'(i + 1)))
                fuse[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ea_latch <= ea_pin;
    end

    assign lvl    = level_of(fuse);
    assign gates  = gates_of(lvl);
    assign ea_eff = (lvl == LVL_OPEN) ? ea_pin : ea_latch;

endmodule

// File: rtl/cg_verify_path.sv
module cg_verify_path
    import codeguard_pkg::*;
#(
    parameter int    ADDR_W   = 16,
    parameter byte_t DEV_CODE = 8'h52
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              rd_sig,
    input  logic [ADDR_W-1:0] rd_addr,
    input  byte_t             rd_code,
    input  byte_t             tbl_byte,
    input  lock_lvl_e         lvl,
    output rd_resp_t          resp
);

    byte_t    sig_val;
    rd_resp_t nxt;

    always_comb begin
        if (rd_addr == ADDR_W'(SIG_MFR_ADR))      sig_val = SIG_MFR_VAL;
        else if (rd_addr == ADDR_W'(SIG_FAM_ADR)) sig_val = SIG_FAM_VAL;
        else if (rd_addr == ADDR_W'(SIG_DEV_ADR)) sig_val = DEV_CODE;
        else                                      sig_val = BLANK;
    end

    always_comb begin
        nxt         = resp;
        nxt.valid   = rd_req;
        nxt.blocked = 1'b0;
        if (rd_req) begin
            if (rd_sig) begin
                nxt.data = sig_val;
            end else if (verify_refused(lvl)) begin
                nxt.data    = BLANK;
                nxt.blocked = 1'b1;
            end else begin
                nxt.data = scramble(rd_code, tbl_byte);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp.valid   <= 1'b0;
            resp.blocked <= 1'b0;
            resp.data    <= BLANK;
        end else begin
            resp <= nxt;
        end
    end

endmodule

// File: rtl/codeguard_top.sv
module codeguard_top
    import codeguard_pkg::*;
#(
    parameter int    ADDR_W    = 16,
    parameter int    TBL_DEPTH = 64,
    parameter byte_t DEV_CODE  = 8'h52,
    localparam int   IDX_W     = $clog2(TBL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ea_pin,
    input  logic              prog_wr,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [7:0]        prog_data,
    input  logic              lock_burn,
    input  logic [1:0]        lock_sel,
    input  logic              erase,
    input  logic              rd_req,
    input  logic              rd_sig,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_code,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              rd_blocked,
    output logic              ext_tblrd_ok,
    output logic              prog_ok,
    output logic              ext_exec_ok,
    output logic              ea_eff
);

    lock_lvl_e lvl;
    gate_t     gates;
    byte_t     tbl_byte;
    rd_resp_t  resp;

    cg_lock_ctrl #(.NFUSE(3)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .erase    (erase),
        .burn_en  (lock_burn),
        .burn_sel (lock_sel),
        .ea_pin   (ea_pin),
        .lvl      (lvl),
        .gates    (gates),
        .ea_eff   (ea_eff)
    );

    cg_scramble_table #(.DEPTH(TBL_DEPTH), .IDX_W(IDX_W)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .erase   (erase),
        .wr_en   (prog_wr && gates.prog_ok),
        .wr_idx  (prog_idx),
        .wr_data (prog_data),
        .rd_idx  (rd_addr[IDX_W-1:0]),
        .rd_byte (tbl_byte)
    );

    cg_verify_path #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_vfy (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .rd_sig   (rd_sig),
        .rd_addr  (rd_addr),
        .rd_code  (rd_code),
        .tbl_byte (tbl_byte),
        .lvl      (lvl),
        .resp     (resp)
    );

    assign rd_valid     = resp.valid;
    assign rd_blocked   = resp.blocked;
    assign rd_data      = resp.data;
    assign ext_tblrd_ok = gates.tblrd_ok;
    assign prog_ok      = gates.prog_ok;
    assign ext_exec_ok  = gates.exec_ok;

endmodule

// File: rtl/cg_checker.sv
module cg_checker
    import codeguard_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       rd_req,
    input logic       rd_sig,
    input logic       rd_valid,
    input logic       rd_blocked,
    input logic [7:0] rd_data,
    input logic       erase,
    input logic       ext_tblrd_ok,
    input logic       prog_ok,
    input logic       ext_exec_ok,
    input logic       ea_eff,
    input lock_lvl_e  lvl
);

    assert_req_valid_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    assert_idle_invalid_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    assert_blocked_blank_R6: assert property (@(posedge clk) disable iff (rst)
        rd_blocked |-> (rd_valid && rd_data == 8'hFF));

    assert_locked_refuses_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_sig && (lvl == LVL_NOVFY || lvl == LVL_NOEXEC)) |=> rd_blocked);

    assert_sig_open_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_sig) |=> !rd_blocked);

    assert_exec_implies_rest_R7: assert property (@(posedge clk) disable iff (rst)
        !ext_exec_ok |-> (!prog_ok && !ext_tblrd_ok));

    assert_erase_opens_R8: assert property (@(posedge clk) disable iff (rst)
        erase |=> (prog_ok && ext_exec_ok && ext_tblrd_ok));

    assert_level_monotone_R10: assert property (@(posedge clk) disable iff (rst)
        !erase |=> (int'(lvl) >= int'($past(lvl))));

    assert_strap_held_R5: assert property (@(posedge clk) disable iff (rst)
        (!ext_tblrd_ok && $past(!ext_tblrd_ok)) |-> $stable(ea_eff));

endmodule

bind codeguard_top cg_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_req       (rd_req),
    .rd_sig       (rd_sig),
    .rd_valid     (rd_valid),
    .rd_blocked   (rd_blocked),
    .rd_data      (rd_data),
    .erase        (erase),
    .ext_tblrd_ok (ext_tblrd_ok),
    .prog_ok      (prog_ok),
    .ext_exec_ok  (ext_exec_ok),
    .ea_eff       (ea_eff),
    .lvl          (lvl)
);

// File: tb/sim_codeguard_top.sv
`timescale 1ns/1ps
module sim_codeguard_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ea_pin = 1'b1;
    logic        prog_wr = 1'b0;
    logic [5:0]  prog_idx = '0;
    logic [7:0]  prog_data = '0;
    logic        lock_burn = 1'b0;
    logic [1:0]  lock_sel = '0;
    logic        erase = 1'b0;
    logic        rd_req = 1'b0;
    logic        rd_sig = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [7:0]  rd_code = '0;
    logic        rd_valid, rd_blocked, ext_tblrd_ok, prog_ok, ext_exec_ok, ea_eff;
    logic [7:0]  rd_data;

    always #2 clk = ~clk;

    codeguard_top u0 (
        .clk(clk), .rst(rst), .ea_pin(ea_pin), .prog_wr(prog_wr), .prog_idx(prog_idx),
        .prog_data(prog_data), .lock_burn(lock_burn), .lock_sel(lock_sel), .erase(erase),
        .rd_req(rd_req), .rd_sig(rd_sig), .rd_addr(rd_addr), .rd_code(rd_code),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_blocked(rd_blocked),
        .ext_tblrd_ok(ext_tblrd_ok), .prog_ok(prog_ok), .ext_exec_ok(ext_exec_ok),
        .ea_eff(ea_eff)
    );

    // ---------------- behavioural reference ----------------
    int    m_tbl [64];
    bit    m_burn [1:3];
    int    m_ea_latch = 1;
    int    m_valid = 0, m_blocked = 0, m_data = 'hFF;
    int    m_in_reset = 1;
    string data_tag = "R2";
    string gate_tag = "R5";
    string cur_data_tag = "R2";

    function automatic int level();
        if (m_burn[3]) return 3;
        if (m_burn[2]) return 2;
        if (m_burn[1]) return 1;
        return 0;
    endfunction

    function automatic int sig_of(int a);
        if (a == 'h30) return 'h89;
        if (a == 'h31) return 'h58;
        if (a == 'h60) return 'h52;
        return 'hFF;
    endfunction

    task automatic wipe();
        foreach (m_tbl[i]) m_tbl[i] = 'hFF;
        for (int k = 1; k <= 3; k++) m_burn[k] = 1'b0;
    endtask

    initial wipe();

    always @(posedge clk) begin
        if (rst) begin
            wipe();
            m_ea_latch = ea_pin;
            m_valid = 0; m_blocked = 0; m_data = 'hFF;
            m_in_reset = 1;
        end else begin
            int lv;
            lv = level();
            m_in_reset = 0;
            m_valid = rd_req;
            m_blocked = 0;
            if (rd_req) begin
                if (rd_sig) begin
                    m_data = sig_of(int'(rd_addr));
                    cur_data_tag = "R9";
                end else if (lv >= 2) begin
                    m_data = 'hFF; m_blocked = 1;
                    cur_data_tag = "R6";
                end else begin
                    m_data = (~(rd_code ^ m_tbl[rd_addr % 64])) & 'hFF;
                    cur_data_tag = data_tag;
                end
            end
            if (erase) begin
                wipe();
            end else begin
                if (prog_wr && lv == 0) m_tbl[prog_idx] = m_tbl[prog_idx] & prog_data;
                if (lock_burn && lock_sel != 0) m_burn[lock_sel] = 1'b1;
            end
        end
    end

    // ---------------- comparison ----------------
    int vectors = 0, miscompares = 0;

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int lv;
        string dt, gt, bt;
        lv = level();
        dt = m_in_reset ? "R1" : cur_data_tag;
        gt = m_in_reset ? "R1" : gate_tag;
        bt = m_in_reset ? "R1" : "R6";
        chk(m_in_reset ? "R1" : "R2", "rd_valid", int'(rd_valid), m_valid);
        chk(bt, "rd_blocked", int'(rd_blocked), m_blocked);
        chk(dt, "rd_data", int'(rd_data), m_data);
        chk(gt, "ext_tblrd_ok", int'(ext_tblrd_ok), int'(lv == 0));
        chk(gt, "prog_ok", int'(prog_ok), int'(lv == 0));
        chk(m_in_reset ? "R1" : "R7", "ext_exec_ok", int'(ext_exec_ok), int'(lv != 3));
        chk(m_in_reset ? "R1" : "R5", "ea_eff", int'(ea_eff), (lv == 0) ? int'(ea_pin) : m_ea_latch);
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        rd_req = 0; rd_sig = 0; prog_wr = 0; lock_burn = 0; erase = 0;
    endtask

    task automatic vread(input logic [15:0] a, input logic [7:0] c);
        rd_req = 1; rd_sig = 0; rd_addr = a; rd_code = c; tick(); tick();
    endtask

    task automatic sread(input logic [15:0] a);
        rd_req = 1; rd_sig = 1; rd_addr = a; tick(); tick();
    endtask

    task automatic twrite(input logic [5:0] i, input logic [7:0] d);
        prog_wr = 1; prog_idx = i; prog_data = d; tick();
    endtask

    task automatic burn(input logic [1:0] s);
        lock_burn = 1; lock_sel = s; tick();
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state, strap high during reset
        tick(); tick(); tick();
        rst = 0;
        tick();
        // R2: unscrambled passthrough with blank table, several patterns
        vread(16'h0000, 8'h00);
        vread(16'h1234, 8'hA5);
        vread(16'hFFFF, 8'h5A);
        // R9: signature bytes
        sread(16'h0030); sread(16'h0031); sread(16'h0060); sread(16'h0032); sread(16'h1030);
        // R3: AND-accumulating table writes
        data_tag = "R3";
        twrite(6'd5, 8'hA5);
        twrite(6'd5, 8'h3C);
        twrite(6'd63, 8'h0F);
        vread(16'h0105, 8'hFF);   // reads table entry 5 = 0x24
        vread(16'hC005, 8'h81);   // same index, different upper bits
        vread(16'h003F, 8'h12);
        vread(16'h0006, 8'h77);   // untouched neighbour
        data_tag = "R2";
        // R5: strap follows the pin while open
        ea_pin = 0; tick(); ea_pin = 1; tick();
        // R4: select 0 is ignored
        gate_tag = "R4";
        burn(2'd0); tick();
        // R5: fuse 1
        burn(2'd1);
        gate_tag = "R5";
        twrite(6'd7, 8'h00);      // must be ignored
        vread(16'h0007, 8'h3C);
        ea_pin = 0; tick(); tick(); ea_pin = 1; tick();
        // R6: fuse 2 blocks verify, R9 signature still open
        burn(2'd2);
        vread(16'h0005, 8'hFF);
        sread(16'h0031);
        // R7/R10: fuse 3 while locked
        gate_tag = "R10";
        burn(2'd3);
        vread(16'h0010, 8'h01);
        // R8: erase beats write and burn in the same cycle
        gate_tag = "R8";
        erase = 1; prog_wr = 1; prog_idx = 6'd5; prog_data = 8'h00; lock_burn = 1; lock_sel = 2'd1;
        tick();
        vread(16'h0005, 8'hFF);
        ea_pin = 0; tick(); ea_pin = 1;
        // R4: only fuse 3 burned -> level 3
        gate_tag = "R4";
        burn(2'd3);
        vread(16'h0001, 8'h00);
        erase = 1; tick();
        gate_tag = "R5";
        // pseudo-random sweep, reference model covers every cycle
        begin
            logic [31:0] lfsr = 32'hACE1_2468;
            for (int n = 0; n < 600; n++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                rd_req    = lfsr[0] | lfsr[1];
                rd_sig    = (lfsr[4:2] == 3'd0);
                rd_addr   = lfsr[5] ? {8'h00, (lfsr[6] ? 8'h30 : 8'h60) | 8'(lfsr[7])} : lfsr[23:8];
                rd_code   = lfsr[31:24];
                prog_wr   = (lfsr[9:8] == 2'd0);
                prog_idx  = lfsr[17:12];
                prog_data = lfsr[27:20];
                lock_burn = (lfsr[14:10] == 5'd3);
                lock_sel  = lfsr[16:15];
                erase     = (lfsr[20:16] == 5'd7);
                ea_pin    = lfsr[19];
                tick();
            end
        end
        tick();
        finish_run();
    end

endmodule